// File: doc/BRIEF.md
# Triplicated ADC Sample Multiplexer with Clock-Domain Framer

This block takes one snapshot of several ADC channels per bunch-crossing clock cycle, walks through the channels one by one with a channel address that steps in Gray code, and hands each sample across to an independent, low-jitter serializer clock through a small asynchronous FIFO. On the serializer side the samples become a byte stream with a control flag per byte, ready for an 8b/10b encoder. Each frame opens with a comma symbol, and commas also fill the line while no frame is in progress.

The address register and the channel multiplexer exist in three copies, and bitwise majority votes combine them. Whenever the copies disagree, a one-cycle mismatch pulse appears and every copy is reloaded from the voted value. A residency limit bounds how long a captured snapshot may sit in the multiplexer. A sample that would overstay is forced into the FIFO even though the FIFO is full. That write is lost, and two sticky flags record the event.

Both stream interfaces follow valid/ready rules. The input snapshot is taken on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` stays low until every channel of that snapshot has left the multiplexer. On the output side, a symbol offered with `out_valid` high and `out_ready` low is held unchanged until it is taken. The channel count and the FIFO depth must be powers of two, the FIFO depth must be at least 4 and at least the channel count, and the sample width must be 9 to 16 bits.

Top module: `adc_mux_framer`

## Requirements
- R1: `in_ready` is high while the multiplexer is empty. A snapshot is captured on a bx_clk edge where `in_valid` and `in_ready` are both high, and `in_ready` is low on the cycle that follows.
- R2: The voted channel address changes by at most one bit per bx_clk cycle. Channels leave in ascending order 0 to CH-1, channel c being `in_data[c*W +: W]`.
- R3: When one address copy holds a wrong value, the voted address and the output data stay correct. `vote_mismatch` is high on the cycle after any disagreement among the copies, and it returns low once all copies have been reloaded with the voted value.
- R4: Samples cross to ser_clk through an 8-entry FIFO with Gray-coded pointers and two-flop synchronizers. No sample is lost, duplicated or reordered while the FIFO never fills.
- R5: A frame is a comma (data 8'hBC with `out_k`=1) followed by two bytes per channel with `out_k`=0. The first byte is the sample's bits W-1..8 zero-extended, and the second byte is bits 7..0. `out_k` is high only for 8'hBC.
- R6: While no frame is in progress, the block offers commas. Between a frame's comma and its last byte it offers no comma, and `out_valid` drops while the FIFO is empty, so every frame carries exactly 2*CH data bytes.
- R7: `out_valid` is high from the first ser_clk edge after reset whenever a symbol is offered. An offered symbol with `out_ready` low keeps the same `out_data` and `out_k` on the next cycle.
- R8: If a captured snapshot still has channels in the multiplexer after LIMIT-1 bx_clk cycles while the FIFO is full, `resid_err` is set and stays set until reset. The remaining channels of that snapshot are discarded at one per cycle, and `in_ready` returns.
- R9: A write into a full FIFO sets `ovf_err`, which stays set until reset. The written data is discarded, and the frames buffered before it are delivered intact.
- R10: After reset, `in_ready` is 1, the output offers a comma, and `vote_mismatch`, `resid_err` and `ovf_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bx_clk | input | 1 | Bunch-crossing clock for capture and multiplexer |
| bx_rst_n | input | 1 | Active-low asynchronous reset, bx_clk domain |
| in_valid | input | 1 | Snapshot on `in_data` is valid |
| in_ready | output | 1 | Multiplexer empty, snapshot may be taken |
| in_data | input | CH*W | Packed samples, channel c at bits c*W +: W |
| ser_clk | input | 1 | Serializer-side clock, independent of bx_clk |
| ser_rst_n | input | 1 | Active-low asynchronous reset, ser_clk domain |
| out_valid | output | 1 | A symbol is offered |
| out_ready | input | 1 | Encoder takes the offered symbol |
| out_data | output | 8 | Symbol byte |
| out_k | output | 1 | Symbol is a control code (comma) |
| vote_mismatch | output | 1 | Address copies disagreed on the previous bx_clk cycle |
| resid_err | output | 1 | Sticky: residency limit reached with the FIFO full |
| ovf_err | output | 1 | Sticky: write attempted into a full FIFO |

## Verification
The bench builds the block with its defaults: eight 12-bit channels, an 8-entry FIFO and a residency limit of 8. With these values a single frame held back by a stalled encoder fills the FIFO exactly, so the next snapshot reaches the residency limit within eight crossings. This brings the timeout, the forced overflow and the recovery of frame alignment within reach of a short directed case. A serializer clock 2.5 times faster than bx_clk, together with random `out_ready` gaps, covers both mid-frame FIFO underrun and held symbols. One address copy is forced to a wrong value to show that the vote masks it and raises the mismatch pulse.

// File: rtl/amf_pkg.sv
package amf_pkg;
  localparam logic [7:0] COMMA_K285 = 8'hBC;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2
  } amf_phase_e;
endpackage

// File: rtl/amf_gray_cnt.sv
// One copy of the channel address register; the next value is computed
// from the voted address, so every copy is reloaded each cycle.
module amf_gray_cnt #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/amf_mux_stage.sv
// Snapshot holding register, triplicated Gray address and multiplexer,
// majority voting and residency limit, all on the bunch-crossing clock.
module amf_mux_stage #(
  parameter int CH    = 8,
  parameter int W     = 12,
  parameter int LIMIT = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CH*W-1:0]         in_data,
  output logic                    wr_en,
  output logic [W-1:0]            wr_data,
  input  logic                    wr_full,
  output logic [$clog2(CH)-1:0]   addr_v,
  output logic                    mismatch,
  output logic                    resid_err
);
  localparam int AW  = $clog2(CH);
  localparam int AGW = $clog2(LIMIT + 1);
  localparam logic [AGW-1:0] AGE_MAX  = AGW'(LIMIT - 1);
  localparam logic [AW-1:0]  LAST_CH  = AW'(CH - 1);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] b2g(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic           busy;
  logic [AGW-1:0] age;
  logic [W-1:0]   hold_q [CH];
  logic [AW-1:0]  cnt    [3];
  logic [W-1:0]   sel    [3];
  logic [AW-1:0]  addr_nxt;
  logic [AW-1:0]  ch_v;
  logic           capture, at_limit, timeout;

  assign in_ready = !busy;
  assign capture  = in_valid && !busy;

  always_ff @(posedge clk) begin
    if (capture) begin
      for (int c = 0; c < CH; c++) hold_q[c] <= in_data[c*W +: W];
    end
  end

  generate
    for (genvar i = 0; i < 3; i++) begin : g_cpy
      amf_gray_cnt #(.AW(AW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (addr_nxt),
        .q     (cnt[i])
      );
      assign sel[i] = hold_q[g2b(cnt[i])];
    end
  endgenerate

  assign addr_v  = (cnt[0] & cnt[1]) | (cnt[0] & cnt[2]) | (cnt[1] & cnt[2]);
  assign wr_data = (sel[0] & sel[1]) | (sel[0] & sel[2]) | (sel[1] & sel[2]);
  assign ch_v    = g2b(addr_v);

  assign at_limit = (age == AGE_MAX);
  assign timeout  = busy && wr_full && at_limit;
  assign wr_en    = busy && (!wr_full || at_limit);
  assign addr_nxt = wr_en ? b2g(ch_v + AW'(1)) : addr_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      age       <= '0;
      resid_err <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      if (capture)                    busy <= 1'b1;
      else if (wr_en && ch_v == LAST_CH) busy <= 1'b0;

      if (capture)                 age <= '0;
      else if (busy && !at_limit)  age <= age + AGW'(1);

      if (timeout) resid_err <= 1'b1;

      mismatch <= (cnt[0] != cnt[1]) || (cnt[0] != cnt[2]);
    end
  end
endmodule

// File: rtl/amf_async_fifo.sv
// Dual-clock FIFO, Gray-coded pointers, two-flop synchronizers.
module amf_async_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 8
) (
  input  logic                     wclk,
  input  logic                     wrst_n,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  output logic                     wr_full,
  output logic                     ovf_err,
  input  logic                     rclk,
  input  logic                     rrst_n,
  input  logic                     rd_en,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   rd_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rbin, rgray, wq1, wq2;
  logic [PW-1:0] wbin_n, rbin_n;

  assign wr_full = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign wbin_n  = wbin + PW'(1);

  always_ff @(posedge wclk) begin
    if (wr_en && !wr_full) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rq1     <= '0;
      rq2     <= '0;
      ovf_err <= 1'b0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_en && !wr_full) begin
        wbin  <= wbin_n;
        wgray <= wbin_n ^ (wbin_n >> 1);
      end
      if (wr_en && wr_full) ovf_err <= 1'b1;
    end
  end

  assign rbin_n   = rbin + PW'(1);
  assign rd_level = g2b(wq2) - rbin;
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_en) begin
        rbin  <= rbin_n;
        rgray <= rbin_n ^ (rbin_n >> 1);
      end
    end
  end
endmodule

// File: rtl/amf_framer.sv
// Serializer-side framer: comma, then high/low byte per channel.
module amf_framer
  import amf_pkg::*;
#(
  parameter int CH    = 8,
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [$clog2(DEPTH):0] level,
  input  logic [W-1:0]           head,
  output logic                   pop,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_k
);
  localparam int IW = (CH > 1) ? $clog2(CH) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(CH - 1);

  amf_phase_e    phase;
  logic [IW-1:0] idx;
  logic          run_q;
  logic [7:0]    hi_b;
  logic          have, accept;

  always_comb begin
    hi_b = '0;
    hi_b[W-9:0] = head[W-1:8];
  end

  assign have      = (level != '0);
  assign out_valid = run_q && (phase == PH_IDLE || have);
  assign accept    = out_valid && out_ready;
  assign pop       = accept && (phase == PH_LO);

  always_comb begin
    unique case (phase)
      PH_HI:   begin out_data = hi_b;       out_k = 1'b0; end
      PH_LO:   begin out_data = head[7:0];  out_k = 1'b0; end
      default: begin out_data = COMMA_K285; out_k = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (accept) begin
        unique case (phase)
          PH_IDLE: if (have) begin phase <= PH_HI; idx <= '0; end
          PH_HI:   phase <= PH_LO;
          PH_LO: begin
            if (idx == LAST_IDX) phase <= PH_IDLE;
            else begin phase <= PH_HI; idx <= idx + IW'(1); end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_mux_framer.sv
module adc_mux_framer #(
  parameter int CH    = 8,
  parameter int W     = 12,
  parameter int DEPTH = 8,
  parameter int LIMIT = 8
) (
  input  logic            bx_clk,
  input  logic            bx_rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CH*W-1:0] in_data,
  input  logic            ser_clk,
  input  logic            ser_rst_n,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            out_k,
  output logic            vote_mismatch,
  output logic            resid_err,
  output logic            ovf_err
);
  localparam int AW = $clog2(CH);
  localparam int PW = $clog2(DEPTH) + 1;

  logic          wr_en, wr_full, pop;
  logic [W-1:0]  wr_data, head;
  logic [PW-1:0] level;
  logic [AW-1:0] mux_addr;
  logic [7:0]    addr_mon;

  assign addr_mon = 8'(mux_addr);

  amf_mux_stage #(.CH(CH), .W(W), .LIMIT(LIMIT)) u_mux (
    .clk       (bx_clk),
    .rst_n     (bx_rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_full   (wr_full),
    .addr_v    (mux_addr),
    .mismatch  (vote_mismatch),
    .resid_err (resid_err)
  );

  amf_async_fifo #(.DW(W), .DEPTH(DEPTH)) u_fifo (
    .wclk     (bx_clk),
    .wrst_n   (bx_rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_full  (wr_full),
    .ovf_err  (ovf_err),
    .rclk     (ser_clk),
    .rrst_n   (ser_rst_n),
    .rd_en    (pop),
    .rd_data  (head),
    .rd_level (level)
  );

  amf_framer #(.CH(CH), .W(W), .DEPTH(DEPTH)) u_frm (
    .clk       (ser_clk),
    .rst_n     (ser_rst_n),
    .level     (level),
    .head      (head),
    .pop       (pop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_k     (out_k)
  );
endmodule

// File: rtl/amf_checker.sv
module amf_checker (
  input logic       bx_clk,
  input logic       bx_rst_n,
  input logic       ser_clk,
  input logic       ser_rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] addr_mon,
  input logic       resid_err,
  input logic       ovf_err,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_k
);
  // R1: capture closes the input until the snapshot has left
  p_capture_closes_r1: assert property (@(posedge bx_clk) disable iff (!bx_rst_n)
    in_valid && in_ready |=> !in_ready);

  // R2: voted address moves by one bit at most
  p_gray_step_r2: assert property (@(posedge bx_clk) disable iff (!bx_rst_n)
    $countones(addr_mon ^ $past(addr_mon)) <= 1);

  // R5: control flag only on the comma code
  p_k_is_comma_r5: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    out_k |-> out_data == 8'hBC);

  // R7: held symbol under back-pressure
  p_hold_symbol_r7: assert property (@(posedge ser_clk) disable iff (!ser_rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_k));

  // R8: residency flag is sticky
  p_resid_sticky_r8: assert property (@(posedge bx_clk) disable iff (!bx_rst_n)
    resid_err |=> resid_err);

  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge bx_clk) disable iff (!bx_rst_n)
    ovf_err |=> ovf_err);
endmodule

bind adc_mux_framer amf_checker u_chk (
  .bx_clk    (bx_clk),
  .bx_rst_n  (bx_rst_n),
  .ser_clk   (ser_clk),
  .ser_rst_n (ser_rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .addr_mon  (addr_mon),
  .resid_err (resid_err),
  .ovf_err   (ovf_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_k     (out_k)
);

// File: tb/adc_mux_framer_test.sv
module adc_mux_framer_test;
  localparam int CH = 8;
  localparam int W  = 12;

  logic            bx_clk = 1'b0, ser_clk = 1'b0;
  logic            bx_rst_n = 1'b0, ser_rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [CH*W-1:0] in_data = '0;
  logic            out_valid, out_ready, out_k;
  logic [7:0]      out_data;
  logic            vote_mismatch, resid_err, ovf_err;

  int         checks = 0, errors = 0;
  bit         ready_en = 1'b0;
  int         rdy_pct = 100;
  string      tag = "R5";
  logic [7:0] expq[$];
  int         dcount = 0;
  bit         pend = 1'b0;
  logic [7:0] pd;
  logic       pk;

  adc_mux_framer uut (
    .bx_clk(bx_clk), .bx_rst_n(bx_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ser_clk(ser_clk), .ser_rst_n(ser_rst_n), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_k(out_k),
    .vote_mismatch(vote_mismatch), .resid_err(resid_err), .ovf_err(ovf_err)
  );

  always #5 bx_clk = ~bx_clk;
  initial begin #1; forever #2 ser_clk = ~ser_clk; end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] hi_byte(input logic [W-1:0] s);
    return 8'(s >> 8);
  endfunction

  function automatic logic [7:0] lo_byte(input logic [W-1:0] s);
    return s[7:0];
  endfunction

  function automatic logic [CH*W-1:0] rand_frame();
    logic [CH*W-1:0] d;
    for (int c = 0; c < CH; c++) d[c*W +: W] = W'($urandom);
    return d;
  endfunction

  // Output monitor and out_ready driver
  always @(negedge ser_clk) begin
    logic r;
    logic [7:0] e;
    r = ready_en && ($urandom_range(0, 99) < rdy_pct);
    out_ready = r;
    if (ser_rst_n) begin
      if (pend)
        check(out_valid && out_data == pd && out_k == pk, "R7", "held symbol",
              {out_k, out_data}, {pk, pd});
      pend = out_valid && !r;
      pd = out_data;
      pk = out_k;
      if (out_valid && r) begin
        if (out_k) begin
          check(out_data == 8'hBC, "R5", "comma code", out_data, 8'hBC);
          if (dcount != 0)
            check(dcount == 2*CH, "R6", "data bytes per frame", dcount, 2*CH);
          dcount = 0;
        end else begin
          if (expq.size() == 0) begin
            check(1'b0, tag, "unexpected data byte", out_data, 0);
          end else begin
            e = expq.pop_front();
            check(out_data == e, tag, "data byte", out_data, e);
          end
          dcount++;
        end
      end
    end
  end

  task automatic send_frame(input logic [CH*W-1:0] d, input bit expect_out);
    @(negedge bx_clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge bx_clk);
    @(posedge bx_clk);
    if (expect_out)
      for (int c = 0; c < CH; c++) begin
        expq.push_back(hi_byte(d[c*W +: W]));
        expq.push_back(lo_byte(d[c*W +: W]));
      end
    @(negedge bx_clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1", "in_ready after capture", in_ready, 0);
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((expq.size() != 0 || (dcount != 0 && dcount != 2*CH)) && n < 5000) begin
      @(negedge ser_clk);
      n++;
    end
    check(expq.size() == 0, "R4", "bytes left undelivered", expq.size(), 0);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R4", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [CH*W-1:0] d;
    void'($urandom(32'd20417));
    repeat (5) @(negedge bx_clk);
    bx_rst_n  = 1'b1;
    ser_rst_n = 1'b1;
    repeat (2) @(negedge bx_clk);

    // R10: reset state
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b1, "R7", "out_valid after reset", out_valid, 1);
    check(out_k == 1'b1 && out_data == 8'hBC, "R10", "idle comma", {out_k, out_data}, 9'h1BC);
    check(vote_mismatch == 1'b0, "R10", "vote_mismatch", vote_mismatch, 0);
    check(resid_err == 1'b0, "R10", "resid_err", resid_err, 0);
    check(ovf_err == 1'b0, "R10", "ovf_err", ovf_err, 0);

    // Directed patterns, channel order made visible (R2)
    ready_en = 1'b1;
    rdy_pct  = 100;
    tag = "R2";
    for (int c = 0; c < CH; c++) d[c*W +: W] = W'(c * 12'h111 + 1);
    send_frame(d, 1'b1);
    tag = "R5";
    send_frame('0, 1'b1);
    send_frame('1, 1'b1);
    wait_drain();

    // Constrained random traffic with encoder back-pressure (R4, R6, R7)
    tag = "R4";
    rdy_pct = 85;
    for (int f = 0; f < 30; f++) begin
      send_frame(rand_frame(), 1'b1);
      repeat ($urandom_range(0, 6)) @(negedge bx_clk);
    end
    wait_drain();

    // Back-to-back snapshots with a ready encoder
    rdy_pct = 100;
    for (int f = 0; f < 6; f++) send_frame(rand_frame(), 1'b1);
    wait_drain();
    check(resid_err == 1'b0, "R8", "no residency error in normal traffic", resid_err, 0);
    check(ovf_err == 1'b0, "R9", "no overflow in normal traffic", ovf_err, 0);

    // R3: one corrupted address copy while idle
    @(negedge bx_clk);
    force uut.u_mux.g_cpy[1].u_cnt.q = 3'b101;
    @(negedge bx_clk);
    check(vote_mismatch == 1'b1, "R3", "mismatch pulse", vote_mismatch, 1);
    release uut.u_mux.g_cpy[1].u_cnt.q;
    repeat (2) @(negedge bx_clk);
    check(vote_mismatch == 1'b0, "R3", "mismatch cleared after reload", vote_mismatch, 0);

    // R3: one copy stuck during a whole frame, vote keeps data correct
    tag = "R3";
    force uut.u_mux.g_cpy[2].u_cnt.q = 3'b011;
    send_frame(rand_frame(), 1'b1);
    check(vote_mismatch == 1'b1, "R3", "mismatch while stuck", vote_mismatch, 1);
    repeat (10) @(negedge bx_clk);
    release uut.u_mux.g_cpy[2].u_cnt.q;
    repeat (3) @(negedge bx_clk);
    wait_drain();

    // R8 / R9: stalled encoder, second snapshot overstays
    ready_en = 1'b0;
    repeat (4) @(negedge ser_clk);
    tag = "R9";
    send_frame(rand_frame(), 1'b1);
    send_frame(rand_frame(), 1'b0);
    repeat (5) @(negedge bx_clk);
    check(resid_err == 1'b0, "R8", "no error before limit", resid_err, 0);
    repeat (4) @(negedge bx_clk);
    check(resid_err == 1'b1, "R8", "residency error at limit", resid_err, 1);
    check(ovf_err == 1'b1, "R9", "overflow on forced write", ovf_err, 1);
    repeat (7) @(negedge bx_clk);
    check(in_ready == 1'b1, "R8", "snapshot discarded, input open", in_ready, 1);
    ready_en = 1'b1;
    wait_drain();
    send_frame(rand_frame(), 1'b1);
    wait_drain();
    check(resid_err == 1'b1, "R8", "residency flag sticky", resid_err, 1);
    check(ovf_err == 1'b1, "R9", "overflow flag sticky", ovf_err, 1);

    repeat (10) @(negedge bx_clk);
    finish_run();
  end
endmodule